// File: doc/BRIEF.md
# Audio Playback DMA Register and Interrupt Front End

This block is the byte-wide control face of an audio playback DMA engine. A simple 8-bit register bus (address, write data, write and read strobes, combinational read data) sets up a transfer. The host loads the DMA configuration, the FIFO threshold, a 32-bit first-byte address and a 32-bit last-byte address, each of them one byte at a time. A write to a command register then starts or aborts the transfer. A reduced transfer model steps a 32-bit byte pointer from the first address to the last address, one byte per clock. When it passes the last byte it drops `busy_o` and records a completion event.

Six event bits collect completion and five externally reported conditions. Each bit is cleared by writing one to it. A per-bit mute register and a separate mask register gate the events into one interrupt line, and a polarity register sets the level of that line. After reset every event is masked, nothing is muted, all events are clear and the line is inactive. The FIFO contents, bus mastering and the audio serializer are not modelled.

Top module: `audio_dma_regs`

## Requirements
- R1: After reset, the registers read back as follows: mask 0xFF, mute 0x00, events 0x00, config 0x00, threshold 0x00, polarity 0xFF, identifier equal to parameter `REV_ID` (default 0x1A). After reset `irq_o` and `busy_o` are both 0.
- R2: Register offsets are:
  - 0x00 config
  - 0x01 go command
  - 0x02 halt command
  - 0x03 threshold
  - 0x04..0x07 first-byte address, least significant byte at 0x04
  - 0x08..0x0B last-byte address, least significant byte at 0x08
  - 0x0C events
  - 0x0D mute
  - 0x0E mask
  - 0x0F polarity
  - 0x10 identifier, read-only

  Each address byte reads back what was written to it. Reading an unmapped offset or a command register returns 0. Read data is 0 while the read strobe is low.
- R3: Writing 1 to bit 0 of the go register sets `busy_o` at that clock edge. With a last address equal to the first address plus N-1, `busy_o` stays 1 for exactly N cycles. It falls at the same edge that sets the completion event.
- R4: The event register has these bits: error at bit 5, lost at bit 4, retry at bit 3, completion at bit 2, buffer-full at bit 1, buffer-empty at bit 0. Writing 1 to a bit clears that bit, and writing 0 leaves it unchanged. A set event is held until it is cleared.
- R5: Input `evt_i` sets event bits 5, 4, 3, 1 and 0 from the matching input bits. Input bit 2 has no effect; completion is set only by the transfer model.
- R6: The mask register gates the events into the interrupt. Mask bit 7 masks completion. Mask bits 5, 4, 3, 1 and 0 mask the event at the same position. A 1 masks the event.
- R7: The mute register is a 6-bit register that uses the event bit positions; a 1 mutes that event. The raw interrupt is the OR of the events that are neither muted nor masked.
- R8: Writing 1 to bit 0 of the halt register ends a transfer. Writing config with bit 7 set (FIFO reset) also ends a transfer. Either one clears `busy_o` at that edge and does not set completion.
- R9: Config keeps bit 3 (bus lock), bits 2:1 (burst length: 0 = 4 beats, 1 = 8 beats, 2 = 16 beats) and bit 0 (burst enable). Bit 7 is a one-cycle request and always reads 0. The threshold register reads back all 8 bits.
- R10: When completion is set in the same cycle as a write-one-to-clear of bit 2, the bit stays set. When a halt arrives in the same cycle that the pointer reaches the last byte, no completion is recorded.
- R11: `irq_o` equals the raw interrupt when polarity bit 0 is 1, and its inverse when polarity bit 0 is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_addr_i | input | ADDR_W | Register offset |
| reg_wdata_i | input | 8 | Write data |
| reg_wr_i | input | 1 | Write strobe |
| reg_rd_i | input | 1 | Read strobe |
| reg_rdata_o | output | 8 | Read data, combinational |
| evt_i | input | 6 | External event pulses at event bit positions |
| irq_o | output | 1 | Interrupt line |
| busy_o | output | 1 | Transfer in progress |

## Verification
Two pairs of actions are made to land on the same clock edge. In the first pair, a one-byte transfer is started and the write-one-to-clear of completion is issued on the very next edge. That edge is also the edge at which the pointer reaches its last byte, and the bench expects completion to read back as set. In the second pair, a halt command is issued on that same edge instead. The bench then expects `busy_o` low and completion clear, which shows that the abort took priority over completion.

// File: rtl/audio_dma_regs.sv
module audio_dma_regs #(
  parameter int ADDR_W = 5,
  parameter int AW = 32,
  parameter logic [7:0] REV_ID = 8'h1A
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [7:0]        reg_wdata_i,
  input  logic              reg_wr_i,
  input  logic              reg_rd_i,
  output logic [7:0]        reg_rdata_o,
  input  logic [5:0]        evt_i,
  output logic              irq_o,
  output logic              busy_o
);
  localparam int NB = AW / 8;
  localparam logic [ADDR_W-1:0] A_CFG = 'h00, A_GO = 'h01, A_HALT = 'h02, A_THR = 'h03,
    A_FIRST = 'h04, A_LAST = 'h08, A_EVT = 'h0C, A_MUTE = 'h0D, A_MASK = 'h0E,
    A_POL = 'h0F, A_REV = 'h10;

  logic [3:0]    cfg_q;
  logic [7:0]    thr_q, mask_q, pol_q;
  logic [5:0]    mute_q, evt_q;
  logic [AW-1:0] first_q, last_q, ptr_q;
  logic          busy_q;

  logic wr_cfg, go, halt, at_end, done_set;
  logic [5:0] set_v, clr_v, mask_v;

  assign wr_cfg   = reg_wr_i && reg_addr_i == A_CFG;
  assign go       = reg_wr_i && reg_addr_i == A_GO && reg_wdata_i[0];
  assign halt     = (reg_wr_i && reg_addr_i == A_HALT && reg_wdata_i[0]) ||
                    (wr_cfg && reg_wdata_i[7]);
  assign at_end   = busy_q && ptr_q == last_q;
  assign done_set = at_end && !halt;
  assign set_v    = {evt_i[5:3], done_set, evt_i[1:0]};
  assign clr_v    = (reg_wr_i && reg_addr_i == A_EVT) ? reg_wdata_i[5:0] : 6'd0;
  assign mask_v   = {mask_q[5:3], mask_q[7], mask_q[1:0]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q   <= '0;
      thr_q   <= '0;
      mask_q  <= 8'hFF;
      pol_q   <= 8'hFF;
      mute_q  <= '0;
      evt_q   <= '0;
      first_q <= '0;
      last_q  <= '0;
    end else begin
      evt_q <= (evt_q & ~clr_v) | set_v;
      if (reg_wr_i) begin
        case (reg_addr_i)
          A_CFG:  cfg_q  <= reg_wdata_i[3:0];
          A_THR:  thr_q  <= reg_wdata_i;
          A_MUTE: mute_q <= reg_wdata_i[5:0];
          A_MASK: mask_q <= reg_wdata_i;
          A_POL:  pol_q  <= reg_wdata_i;
          default: ;
        endcase
        for (int i = 0; i < NB; i++) begin
          if (reg_addr_i == A_FIRST + ADDR_W'(i)) first_q[8*i +: 8] <= reg_wdata_i;
          if (reg_addr_i == A_LAST + ADDR_W'(i))  last_q[8*i +: 8]  <= reg_wdata_i;
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      ptr_q  <= '0;
    end else if (halt) begin
      busy_q <= 1'b0;
    end else if (go) begin
      busy_q <= 1'b1;
      ptr_q  <= first_q;
    end else if (busy_q) begin
      if (at_end) busy_q <= 1'b0;
      else        ptr_q  <= ptr_q + 1'b1;
    end
  end

  logic [7:0] rd_mux;
  always_comb begin
    rd_mux = 8'h00;
    case (reg_addr_i)
      A_CFG:  rd_mux = {4'h0, cfg_q};
      A_THR:  rd_mux = thr_q;
      A_EVT:  rd_mux = {2'b00, evt_q};
      A_MUTE: rd_mux = {2'b00, mute_q};
      A_MASK: rd_mux = mask_q;
      A_POL:  rd_mux = pol_q;
      A_REV:  rd_mux = REV_ID;
      default: ;
    endcase
    for (int i = 0; i < NB; i++) begin
      if (reg_addr_i == A_FIRST + ADDR_W'(i)) rd_mux = first_q[8*i +: 8];
      if (reg_addr_i == A_LAST + ADDR_W'(i))  rd_mux = last_q[8*i +: 8];
    end
  end

  logic irq_raw;
  assign irq_raw     = |(evt_q & ~mute_q & ~mask_v);
  assign irq_o       = pol_q[0] ? irq_raw : !irq_raw;
  assign busy_o      = busy_q;
  assign reg_rdata_o = reg_rd_i ? rd_mux : 8'h00;
endmodule

// File: rtl/audio_dma_regs_chk.sv
module audio_dma_regs_chk #(
  parameter int ADDR_W = 5,
  parameter int AW = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] reg_addr_i,
  input logic [7:0]        reg_wdata_i,
  input logic              reg_wr_i,
  input logic [5:0]        evt_i,
  input logic              busy_o,
  input logic [AW-1:0]     ptr_q,
  input logic [AW-1:0]     last_q,
  input logic [5:0]        evt_q,
  input logic [5:0]        mute_q
);
  logic abort_in;
  assign abort_in = reg_wr_i && ((reg_addr_i == 'h02 && reg_wdata_i[0]) ||
                                 (reg_addr_i == 'h00 && reg_wdata_i[7]));

  assert_done_at_end_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && ptr_q == last_q && !abort_in) |=> evt_q[2]);

  assert_halt_idles_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_in |=> !busy_o);

  assert_w1c_clears_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_wr_i && reg_addr_i == 'h0C && evt_i == 6'd0 && !busy_o) |=>
    ((evt_q & $past(reg_wdata_i[5:0])) == 6'd0));

  assert_empty_needs_cause_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!evt_i[0] && !evt_q[0]) |=> !evt_q[0]);

  assert_done_only_from_engine_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !evt_q[2]) |=> !evt_q[2]);

  assert_event_held_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_q[5] && !(reg_wr_i && reg_addr_i == 'h0C)) |=> evt_q[5]);
endmodule

bind audio_dma_regs audio_dma_regs_chk #(.ADDR_W(ADDR_W), .AW(AW)) chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .reg_addr_i(reg_addr_i), .reg_wdata_i(reg_wdata_i),
  .reg_wr_i(reg_wr_i), .evt_i(evt_i), .busy_o(busy_o), .ptr_q(ptr_q),
  .last_q(last_q), .evt_q(evt_q), .mute_q(mute_q)
);

// File: tb/audio_dma_regs_tb_top.sv
`timescale 1ns/1ps
module audio_dma_regs_tb_top;
  logic clk = 0, rst_n = 0;
  logic [4:0] addr = 0;
  logic [7:0] wdata = 0, rdata;
  logic wr = 0, rd = 0, irq, busy;
  logic [5:0] evt = 0;
  int checks = 0, errors = 0;
  logic [7:0] exp_q[$];
  string req_q[$];

  always #10 clk = ~clk;

  audio_dma_regs dut_i (.clk_i(clk), .rst_ni(rst_n), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_wr_i(wr), .reg_rd_i(rd), .reg_rdata_o(rdata),
    .evt_i(evt), .irq_o(irq), .busy_o(busy));

  // monitor: pop expected read data and compare mid-cycle
  always @(negedge clk) if (rd) begin
    if (exp_q.size() == 0) begin
      errors++; $display("FAIL scoreboard empty, rdata %h expected none", rdata);
    end else begin
      logic [7:0] e; string r;
      e = exp_q.pop_front(); r = req_q.pop_front();
      checks++;
      if (rdata !== e) begin
        errors++; $display("FAIL %s addr %h: got %h expected %h", r, addr, rdata, e);
      end
    end
  end

  task automatic wr_reg(input logic [4:0] a, input logic [7:0] d);
    addr = a; wdata = d; wr = 1;
    @(posedge clk); #1 wr = 0;
  endtask

  task automatic rd_chk(input logic [4:0] a, input logic [7:0] e, input string r);
    exp_q.push_back(e); req_q.push_back(r);
    addr = a; rd = 1;
    @(posedge clk); #1 rd = 0;
  endtask

  task automatic pin_chk(input logic act, input logic e, input string r);
    checks++;
    if (act !== e) begin
      errors++; $display("FAIL %s pin: got %b expected %b", r, act, e);
    end
  endtask

  initial begin
    #(200000 * 20);
    errors++; $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (2) @(posedge clk);
    #1 rst_n = 1;
    // R1 reset state
    pin_chk(irq, 0, "R1"); pin_chk(busy, 0, "R1");
    rd_chk(5'h0E, 8'hFF, "R1"); rd_chk(5'h0D, 8'h00, "R1");
    rd_chk(5'h0C, 8'h00, "R1"); rd_chk(5'h00, 8'h00, "R1");
    rd_chk(5'h03, 8'h00, "R1"); rd_chk(5'h0F, 8'hFF, "R1");
    rd_chk(5'h10, 8'h1A, "R1");
    // R2 address bytes, little-endian
    wr_reg(5'h04, 8'h10); wr_reg(5'h05, 8'h20); wr_reg(5'h06, 8'h30); wr_reg(5'h07, 8'h40);
    wr_reg(5'h08, 8'h13); wr_reg(5'h09, 8'h20); wr_reg(5'h0A, 8'h30); wr_reg(5'h0B, 8'h40);
    rd_chk(5'h04, 8'h10, "R2"); rd_chk(5'h07, 8'h40, "R2"); rd_chk(5'h08, 8'h13, "R2");
    rd_chk(5'h0B, 8'h40, "R2"); rd_chk(5'h11, 8'h00, "R2"); rd_chk(5'h01, 8'h00, "R2");
    #1 pin_chk(rdata === 8'h00, 1, "R2");
    // R3 four-byte transfer
    wr_reg(5'h01, 8'h01);
    pin_chk(busy, 1, "R3");
    repeat (3) @(posedge clk);
    #1 pin_chk(busy, 1, "R3");
    @(posedge clk); #1 pin_chk(busy, 0, "R3");
    rd_chk(5'h0C, 8'h04, "R3");
    // R6 / R7 gating
    pin_chk(irq, 0, "R6");
    wr_reg(5'h0E, 8'h7F); pin_chk(irq, 1, "R6");
    wr_reg(5'h0D, 8'h04); pin_chk(irq, 0, "R7");
    wr_reg(5'h0D, 8'h00); pin_chk(irq, 1, "R7");
    // R11 polarity
    wr_reg(5'h0F, 8'hFE); pin_chk(irq, 0, "R11");
    wr_reg(5'h0F, 8'hFF); pin_chk(irq, 1, "R11");
    // R4 write-one-to-clear
    wr_reg(5'h0C, 8'h00); rd_chk(5'h0C, 8'h04, "R4");
    wr_reg(5'h0C, 8'h04); rd_chk(5'h0C, 8'h00, "R4"); pin_chk(irq, 0, "R4");
    // R5 external events, bit 2 ignored
    evt = 6'h27; @(posedge clk); #1 evt = 0;
    rd_chk(5'h0C, 8'h23, "R5");
    pin_chk(irq, 0, "R6");
    wr_reg(5'h0E, 8'hFE); pin_chk(irq, 1, "R6");
    wr_reg(5'h0E, 8'hFF); pin_chk(irq, 0, "R6");
    wr_reg(5'h0C, 8'h21); rd_chk(5'h0C, 8'h02, "R4");
    wr_reg(5'h0C, 8'h3F);
    // R8 halt mid-transfer
    wr_reg(5'h01, 8'h01); wr_reg(5'h02, 8'h01);
    pin_chk(busy, 0, "R8");
    repeat (6) @(posedge clk);
    #1 rd_chk(5'h0C, 8'h00, "R8");
    // R8 / R9 FIFO reset via config
    wr_reg(5'h01, 8'h01); wr_reg(5'h00, 8'h8D);
    pin_chk(busy, 0, "R8");
    repeat (6) @(posedge clk);
    #1 rd_chk(5'h0C, 8'h00, "R8");
    rd_chk(5'h00, 8'h0D, "R9");
    wr_reg(5'h03, 8'h80); rd_chk(5'h03, 8'h80, "R9");
    // R10 collisions with a one-byte transfer
    wr_reg(5'h08, 8'h10);
    wr_reg(5'h01, 8'h01); wr_reg(5'h0C, 8'h04);
    pin_chk(busy, 0, "R10");
    rd_chk(5'h0C, 8'h04, "R10");
    wr_reg(5'h0C, 8'h04);
    wr_reg(5'h01, 8'h01); wr_reg(5'h02, 8'h01);
    pin_chk(busy, 0, "R10");
    rd_chk(5'h0C, 8'h00, "R10");
    repeat (2) @(posedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule